// File: doc/BRIEF.md
# Input Sample Error Detector

This block watches the parallel sample stream of a two-channel I/Q converter interface and compares every accepted sample with a four-entry reference sequence, I0, Q0, I1, Q1, which then starts again. Software loads each 16-bit reference sample as two bytes through a small register port. A frame strobe that arrives with a sample marks that sample as I0, so the sequence lines up with the stream.

When an enabled comparison finds a difference, two flags are set: a fail bit in the control register and an error flag in the interrupt status register. The differing bit positions are ORed into one of two sticky masks. I-slot samples feed the I mask and Q-slot samples feed the Q mask. These masks gather every failed bit since the last clear. Each flag and mask bit is cleared by writing a 1 to it. When the detector is turned on the frame alignment is unknown, so software is expected to clear the flags once right after enabling it. The interrupt output is a level that follows the error flag, gated by its enable bit.

Top module: `sample_error_detector`

## Requirements
- R1: After reset every register reads 0 and irq is low.
- R2: Reference bytes are written and read at address 0x08 + 2*s + b. Slot s is 0=I0, 1=Q0, 2=I1, 3=Q1. Byte b is 0 for bits 7:0 and 1 for bits 15:8.
- R3: Each sample with smp_valid high moves the slot pointer one step through I0, Q0, I1, Q1 and back to I0. A sample that arrives with smp_frame high is compared against I0, and the sample after it is compared against Q0.
- R4: When an enabled sample differs from its reference, the fail bit (bit 1 of control address 0x00) and the error flag (bit 0 of status address 0x02) both read 1 from the clock edge that takes the sample.
- R5: The XOR of the received and expected samples is ORed into the I mask (0x10 low byte, 0x11 high byte) for slots I0 and I1. It is ORed into the Q mask (0x12 low byte, 0x13 high byte) for slots Q0 and I1's partner slots Q0 and Q1. Bits stay set while further samples arrive.
- R6: Writing a 1 to a fail, flag or mask bit clears that bit. Writing a 0 leaves it unchanged. A clear written in the same cycle as a new error wins for that cycle only.
- R7: irq is high exactly when the error flag is set and the interrupt enable (bit 0 of address 0x01) is 1. It stays high until the flag is cleared.
- R8: While the enable (bit 0 of 0x00) is 0, no sample changes a flag or a mask, and turning the detector off keeps their values.
- R9: Samples that match set nothing. Cycles with smp_valid low neither compare nor move the pointer.
- R10: The enable bit and the interrupt enable read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_frame | input | 1 | The present sample is I0 |
| smp_data | input | 16 | Received sample |
| irq | output | 1 | Interrupt request, level |

## Verification
The assertions assume that reset holds for at least one edge and that smp_frame is ignored unless smp_valid is high. They also assume that a register write and a sample may coincide in any cycle. The bench drives each sample for one cycle with an idle cycle after it. It raises the frame strobe at the start of every checked group, so the expected reference slot is always known. One directed case puts a flag clear and a mismatching sample in the same cycle on purpose, to test the case where the clear wins.

// File: rtl/sed_pkg.sv
package sed_pkg;

  localparam int unsigned REG_AW = 8;

  localparam logic [REG_AW-1:0] ADR_CTRL  = 8'h00;
  localparam logic [REG_AW-1:0] ADR_IRQEN = 8'h01;
  localparam logic [REG_AW-1:0] ADR_IRQST = 8'h02;
  localparam logic [REG_AW-1:0] ADR_REF   = 8'h08;
  localparam logic [REG_AW-1:0] ADR_MASK  = 8'h10;

  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_FAIL_BIT = 1;

  typedef enum logic [1:0] {
    SLOT_I0 = 2'd0,
    SLOT_Q0 = 2'd1,
    SLOT_I1 = 2'd2,
    SLOT_Q1 = 2'd3
  } slot_e;

  localparam int unsigned NSLOT = 4;

  function automatic slot_e slot_after(slot_e cur, logic frame);
    slot_e base;
    base = frame ? SLOT_I0 : cur;
    return slot_e'(base + 2'd1);
  endfunction

  function automatic logic slot_is_q(slot_e s);
    return s[0];
  endfunction

endpackage

// File: rtl/sed_cfg.sv
module sed_cfg
  import sed_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned BW = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [REG_AW-1:0]             wr_addr,
  input  logic [BW-1:0]                 wr_data,
  input  logic [REG_AW-1:0]             rd_addr,
  output logic [BW-1:0]                 rd_data,
  input  logic                          fail_q,
  input  logic                          flag_q,
  input  logic [DW-1:0]                 mask_i,
  input  logic [DW-1:0]                 mask_q,
  output logic [NSLOT-1:0][DW-1:0]      ref_q,
  output logic                          det_en,
  output logic                          irq_en,
  output logic                          clr_fail,
  output logic                          clr_flag,
  output logic [DW-1:0]                 clr_mask_i,
  output logic [DW-1:0]                 clr_mask_q
);

  localparam int unsigned NB = DW / BW;

  function automatic logic [REG_AW-1:0] ref_adr(int unsigned s, int unsigned b);
    return REG_AW'(ADR_REF + s * NB + b);
  endfunction

  function automatic logic [REG_AW-1:0] mask_adr(int unsigned side, int unsigned b);
    return REG_AW'(ADR_MASK + side * NB + b);
  endfunction

  logic wr_ctrl, wr_irqen, wr_irqst;
  assign wr_ctrl  = wr_en && (wr_addr == ADR_CTRL);
  assign wr_irqen = wr_en && (wr_addr == ADR_IRQEN);
  assign wr_irqst = wr_en && (wr_addr == ADR_IRQST);

  assign clr_fail = wr_ctrl  && wr_data[CTRL_FAIL_BIT];
  assign clr_flag = wr_irqst && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_en <= 1'b0;
      irq_en <= 1'b0;
    end else begin
      if (wr_ctrl)  det_en <= wr_data[CTRL_EN_BIT];
      if (wr_irqen) irq_en <= wr_data[0];
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    for (genvar b = 0; b < NB; b++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          ref_q[s][b*BW +: BW] <= '0;
        else if (wr_en && (wr_addr == ref_adr(s, b)))
          ref_q[s][b*BW +: BW] <= wr_data;
      end
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_clr
    assign clr_mask_i[b*BW +: BW] = (wr_en && (wr_addr == mask_adr(0, b))) ? wr_data : '0;
    assign clr_mask_q[b*BW +: BW] = (wr_en && (wr_addr == mask_adr(1, b))) ? wr_data : '0;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADR_CTRL) begin
      rd_data[CTRL_EN_BIT]   = det_en;
      rd_data[CTRL_FAIL_BIT] = fail_q;
    end
    if (rd_addr == ADR_IRQEN) rd_data[0] = irq_en;
    if (rd_addr == ADR_IRQST) rd_data[0] = flag_q;
    for (int s = 0; s < NSLOT; s++)
      for (int b = 0; b < NB; b++)
        if (rd_addr == ref_adr(s, b)) rd_data = ref_q[s][b*BW +: BW];
    for (int b = 0; b < NB; b++) begin
      if (rd_addr == mask_adr(0, b)) rd_data = mask_i[b*BW +: BW];
      if (rd_addr == mask_adr(1, b)) rd_data = mask_q[b*BW +: BW];
    end
  end

  p_enable_written_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> det_en == $past(wr_data[CTRL_EN_BIT]));

  p_irqen_written_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_irqen |=> irq_en == $past(wr_data[0]));

endmodule

// File: rtl/sed_cmp.sv
module sed_cmp
  import sed_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic                     smp_frame,
  input  logic [DW-1:0]            smp_data,
  input  logic                     det_en,
  input  logic [NSLOT-1:0][DW-1:0] ref_q,
  output slot_e                    slot_q,
  output logic                     hit,
  output logic                     hit_on_q,
  output logic [DW-1:0]            hit_bits
);

  function automatic logic [DW-1:0] bit_diff(logic [DW-1:0] got, logic [DW-1:0] want);
    return got ^ want;
  endfunction

  slot_e         cur_slot;
  logic [DW-1:0] expect_w;
  logic [DW-1:0] diff_w;

  assign cur_slot = smp_frame ? SLOT_I0 : slot_q;
  assign expect_w = ref_q[cur_slot];
  assign diff_w   = bit_diff(smp_data, expect_w);
  assign hit      = smp_valid && det_en && (|diff_w);
  assign hit_on_q = slot_is_q(cur_slot);
  assign hit_bits = hit ? diff_w : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      slot_q <= SLOT_I0;
    else if (smp_valid)
      slot_q <= slot_after(slot_q, smp_frame);
  end

  p_frame_realign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && smp_frame |=> slot_q == SLOT_Q0);

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !smp_frame |=> slot_q == slot_e'($past(slot_q) + 2'd1));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(slot_q));

endmodule

// File: rtl/sed_sticky.sv
module sed_sticky #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic          hit_on_q,
  input  logic [DW-1:0] hit_bits,
  input  logic          clr_fail,
  input  logic          clr_flag,
  input  logic [DW-1:0] clr_mask_i,
  input  logic [DW-1:0] clr_mask_q,
  output logic          fail_q,
  output logic          flag_q,
  output logic [DW-1:0] mask_i,
  output logic [DW-1:0] mask_q
);

  function automatic logic [DW-1:0] hold_or_clear(logic [DW-1:0] old,
                                                  logic [DW-1:0] set,
                                                  logic [DW-1:0] clr);
    return (old | set) & ~clr;
  endfunction

  logic [DW-1:0] set_i, set_q;
  assign set_i = hit_on_q ? '0 : hit_bits;
  assign set_q = hit_on_q ? hit_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q <= 1'b0;
      flag_q <= 1'b0;
      mask_i <= '0;
      mask_q <= '0;
    end else begin
      fail_q <= (fail_q | hit) & ~clr_fail;
      flag_q <= (flag_q | hit) & ~clr_flag;
      mask_i <= hold_or_clear(mask_i, set_i, clr_mask_i);
      mask_q <= hold_or_clear(mask_q, set_q, clr_mask_q);
    end
  end

  p_hit_sets_fail_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !clr_fail |=> fail_q);

  p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_flag |=> !flag_q);

  p_flag_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !clr_flag |=> flag_q);

  p_mask_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_mask_i == '0 |=> (mask_i & $past(mask_i)) == $past(mask_i));

endmodule

// File: rtl/sample_error_detector.sv
module sample_error_detector
  import sed_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned BW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [BW-1:0]     wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [BW-1:0]     rd_data,
  input  logic              smp_valid,
  input  logic              smp_frame,
  input  logic [DW-1:0]     smp_data,
  output logic              irq
);

  logic [NSLOT-1:0][DW-1:0] ref_q;
  logic          det_en, irq_en;
  logic          clr_fail, clr_flag;
  logic [DW-1:0] clr_mask_i, clr_mask_q;
  logic          fail_q, flag_q;
  logic [DW-1:0] mask_i, mask_q;
  slot_e         slot_q;
  logic          hit, hit_on_q;
  logic [DW-1:0] hit_bits;

  sed_cfg #(.DW(DW), .BW(BW)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .fail_q(fail_q), .flag_q(flag_q), .mask_i(mask_i), .mask_q(mask_q),
    .ref_q(ref_q), .det_en(det_en), .irq_en(irq_en),
    .clr_fail(clr_fail), .clr_flag(clr_flag),
    .clr_mask_i(clr_mask_i), .clr_mask_q(clr_mask_q)
  );

  sed_cmp #(.DW(DW)) u_cmp (
    .clk(clk), .rst_n(rst_n),
    .smp_valid(smp_valid), .smp_frame(smp_frame), .smp_data(smp_data),
    .det_en(det_en), .ref_q(ref_q),
    .slot_q(slot_q), .hit(hit), .hit_on_q(hit_on_q), .hit_bits(hit_bits)
  );

  sed_sticky #(.DW(DW)) u_sticky (
    .clk(clk), .rst_n(rst_n),
    .hit(hit), .hit_on_q(hit_on_q), .hit_bits(hit_bits),
    .clr_fail(clr_fail), .clr_flag(clr_flag),
    .clr_mask_i(clr_mask_i), .clr_mask_q(clr_mask_q),
    .fail_q(fail_q), .flag_q(flag_q), .mask_i(mask_i), .mask_q(mask_q)
  );

  assign irq = flag_q & irq_en;

  p_off_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en && clr_mask_i == '0 && clr_mask_q == '0 && !clr_flag
    |=> $stable(mask_i) && $stable(mask_q) && $stable(flag_q));

  p_match_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !hit && !flag_q |=> !flag_q);

endmodule

// File: tb/test_sample_error_detector.sv
module test_sample_error_detector;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        smp_valid = 1'b0;
  logic        smp_frame = 1'b0;
  logic [15:0] smp_data = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [15:0] rv [4];

  always #2 clk = ~clk;

  sample_error_detector i_sample_error_detector (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .smp_valid(smp_valid), .smp_frame(smp_frame), .smp_data(smp_data),
    .irq(irq)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [7:0] exp);
    @(negedge clk);
    rd_addr = a;
    #1;
    chk(tag, {8'h00, rd_data}, {8'h00, exp});
  endtask

  task automatic irq_chk(string tag, logic exp);
    @(negedge clk);
    #1;
    chk(tag, {15'h0, irq}, {15'h0, exp});
  endtask

  task automatic send(logic [15:0] d, logic f);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = d; smp_frame = f;
    @(negedge clk);
    smp_valid = 1'b0; smp_frame = 1'b0;
  endtask

  task automatic clear_all();
    wr(8'h02, 8'h01);
    wr(8'h00, 8'h03);
    for (int k = 0; k < 4; k++) wr(8'h10 + 8'(k), 8'hFF);
  endtask

  task automatic t_reset();
    chk("R1 irq after reset", {15'h0, irq}, 16'h0);
    rd_chk("R1 ctrl", 8'h00, 8'h00);
    rd_chk("R1 irq enable", 8'h01, 8'h00);
    rd_chk("R1 flag", 8'h02, 8'h00);
    for (int a = 8'h08; a < 8'h10; a++) rd_chk("R1 reference", 8'(a), 8'h00);
    for (int a = 8'h10; a < 8'h14; a++) rd_chk("R1 mask", 8'(a), 8'h00);
  endtask

  task automatic t_refs();
    rv[0] = 16'hA5C3; rv[1] = 16'h5A3C; rv[2] = 16'h0FF0; rv[3] = 16'hF00F;
    for (int s = 0; s < 4; s++) begin
      wr(8'h08 + 8'(2*s), rv[s][7:0]);
      wr(8'h09 + 8'(2*s), rv[s][15:8]);
    end
    for (int s = 0; s < 4; s++) begin
      rd_chk("R2 ref low byte", 8'h08 + 8'(2*s), rv[s][7:0]);
      rd_chk("R2 ref high byte", 8'h09 + 8'(2*s), rv[s][15:8]);
    end
  endtask

  task automatic t_match();
    wr(8'h00, 8'h03);
    wr(8'h02, 8'h01);
    rd_chk("R10 enable readback", 8'h00, 8'h01);
    send(rv[0], 1'b1); send(rv[1], 1'b0); send(rv[2], 1'b0);
    send(rv[3], 1'b0); send(rv[0], 1'b0); send(rv[1], 1'b0);
    rd_chk("R9 no fail on match", 8'h00, 8'h01);
    rd_chk("R3 R9 no flag over wrap", 8'h02, 8'h00);
    for (int a = 8'h10; a < 8'h14; a++) rd_chk("R9 masks clean", 8'(a), 8'h00);
  endtask

  task automatic t_mismatch();
    send(rv[0] ^ 16'h0001, 1'b1);
    rd_chk("R4 fail set", 8'h00, 8'h03);
    rd_chk("R4 flag set", 8'h02, 8'h01);
    rd_chk("R5 I mask low", 8'h10, 8'h01);
    send(rv[1] ^ 16'h8000, 1'b0);
    rd_chk("R5 Q mask high", 8'h13, 8'h80);
    rd_chk("R5 Q mask low untouched", 8'h12, 8'h00);
    send(rv[2] ^ 16'h0100, 1'b0);
    rd_chk("R5 I mask high from I1", 8'h11, 8'h01);
    rd_chk("R5 I mask low kept", 8'h10, 8'h01);
    send(rv[3], 1'b0);
    rd_chk("R5 Q mask high kept", 8'h13, 8'h80);
    irq_chk("R7 irq gated off", 1'b0);
    wr(8'h01, 8'h01);
    rd_chk("R10 irq enable readback", 8'h01, 8'h01);
    irq_chk("R7 irq on", 1'b1);
    repeat (3) @(negedge clk);
    irq_chk("R7 irq level held", 1'b1);
  endtask

  task automatic t_clear();
    wr(8'h00, 8'h01);
    rd_chk("R6 zero write keeps fail", 8'h00, 8'h03);
    wr(8'h00, 8'h03);
    rd_chk("R6 fail cleared", 8'h00, 8'h01);
    irq_chk("R7 irq follows flag not fail", 1'b1);
    wr(8'h02, 8'h01);
    rd_chk("R6 flag cleared", 8'h02, 8'h00);
    irq_chk("R7 irq drops on clear", 1'b0);
    wr(8'h10, 8'h01);
    rd_chk("R6 I mask low cleared", 8'h10, 8'h00);
    rd_chk("R6 I mask high kept", 8'h11, 8'h01);
    wr(8'h11, 8'hFF); wr(8'h13, 8'hFF);
    rd_chk("R6 I mask high cleared", 8'h11, 8'h00);
    rd_chk("R6 Q mask high cleared", 8'h13, 8'h00);
  endtask

  task automatic t_frame();
    logic [15:0] d;
    send(rv[0], 1'b0);
    send(rv[0], 1'b1);
    send(rv[1], 1'b0);
    rd_chk("R3 realigned no flag", 8'h02, 8'h00);
    send(rv[1], 1'b1);
    d = rv[0] ^ rv[1];
    rd_chk("R3 frame compares I0 low", 8'h10, d[7:0]);
    rd_chk("R3 frame compares I0 high", 8'h11, d[15:8]);
    send(rv[1], 1'b0);
    rd_chk("R3 next is Q0", 8'h12, 8'h00);
    clear_all();
    irq_chk("R6 all cleared irq", 1'b0);
  endtask

  task automatic t_race();
    send(rv[0], 1'b1);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'h02; wr_data = 8'h01;
    smp_valid = 1'b1; smp_frame = 1'b0; smp_data = rv[1] ^ 16'h0010;
    @(negedge clk);
    wr_en = 1'b0; smp_valid = 1'b0;
    rd_chk("R6 clear wins same cycle", 8'h02, 8'h00);
    irq_chk("R6 irq stays low", 1'b0);
    rd_chk("R4 fail still set", 8'h00, 8'h03);
    rd_chk("R5 Q mask low set", 8'h12, 8'h10);
    send(rv[2] ^ 16'h0002, 1'b0);
    rd_chk("R6 next error sets flag", 8'h02, 8'h01);
    irq_chk("R7 irq after next error", 1'b1);
    rd_chk("R5 I mask low", 8'h10, 8'h02);
  endtask

  task automatic t_disabled();
    wr(8'h02, 8'h01);
    wr(8'h00, 8'h02);
    rd_chk("R8 disabled ctrl", 8'h00, 8'h00);
    send(~rv[0], 1'b1);
    send(~rv[1], 1'b0);
    rd_chk("R8 no flag while off", 8'h02, 8'h00);
    rd_chk("R8 no fail while off", 8'h00, 8'h00);
    rd_chk("R8 I mask kept", 8'h10, 8'h02);
    rd_chk("R8 I mask high kept", 8'h11, 8'h00);
    rd_chk("R8 Q mask kept", 8'h12, 8'h10);
    rd_chk("R8 Q mask high kept", 8'h13, 8'h00);
    irq_chk("R8 irq low while off", 1'b0);
    wr(8'h00, 8'h01);
    send(rv[0], 1'b1);
    send(rv[1] ^ 16'h0400, 1'b0);
    rd_chk("R8 re-enabled detects", 8'h02, 8'h01);
    rd_chk("R8 re-enabled Q mask", 8'h13, 8'h04);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_refs();
    t_match();
    t_mismatch();
    t_clear();
    t_frame();
    t_race();
    t_disabled();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule